// File: doc/BRIEF.md
# Banked Strided Vector Load Unit

This block fetches one vector from an interleaved memory into a vector register. A start command supplies a base word address, a stride, a vector length and a mode bit. The unit works out the word address of each element and sends the elements, one at a time and in ascending index order, to sixteen single-ported banks that are modelled inside the block. Each returned word is written into the vector register port, tagged with its element index. A done flag reports that the whole vector has arrived.

A bank that has just accepted an access stays busy for a few cycles. When the next element maps to a busy bank, issue waits for that bank, so the issue rate depends on how the stride spreads the elements over the banks. In gather mode, element addresses come from a per-element offset vector added to the base, and the stride is not used.

A four-state machine sequences the unit. The states are ST_IDLE (after reset), ST_ISSUE (elements being sent), ST_DRAIN (all sent, words still returning) and ST_DONE (finished, done high). The transitions are:
- ST_IDLE or ST_DONE to ST_ISSUE on an accepted start with a non-zero length.
- ST_IDLE or ST_DONE to ST_DONE on an accepted start with zero length.
- ST_ISSUE to ST_DRAIN when the last element is issued.
- ST_DRAIN to ST_DONE when the last element is written.

Top module: `vec_bank_load`

## Requirements
- R1: The bank of an access is the low 4 bits of its 16-bit word address. Accesses to different banks may issue on consecutive cycles, with at most one access per cycle.
- R2: A bank that accepts an access in cycle t accepts no other access before cycle t+4. The first element is issued in the cycle after the start is accepted.
- R3: In strided mode (`gather`=0), element i reads word address (base + i*stride) mod 2^16. Stride 0 repeats the base, and stride 0xFFFF walks downward.
- R4: In gather mode (`gather`=1), element i reads (base + offset_i) mod 2^16, where offset_i is `idx_vec[16*i+15:16*i]`.
- R5: Elements are issued in ascending index order, and an element waiting for a busy bank holds back all later ones. The word for an element issued in cycle t appears on the write port in cycle t+12 with its index. The word stored at address a is {a ^ 16'hA5C3, a}.
- R6: `done` rises in the cycle after the last element is written and stays high until the next start is accepted. An accepted start with a non-zero length clears it in the following cycle.
- R7: A length of zero raises `done` in the cycle after the start and makes no memory request.
- R8: A length above 64 is treated as 64.
- R9: A start that arrives while a load is in ST_ISSUE or ST_DRAIN is ignored and does not change that load.
- R10: After reset the unit is idle: no request, no register write, and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start command strobe |
| gather | input | 1 | 1 selects offset-vector addressing, 0 selects strided addressing |
| base | input | 16 | Base word address |
| stride | input | 16 | Stride in words, taken modulo 2^16 |
| vlen | input | 7 | Vector length, clamped to 64 |
| idx_vec | input | 1024 | Offset vector, 16 bits per element |
| mem_req | output | 1 | A bank access is issued this cycle |
| mem_addr | output | 16 | Word address of the issued access |
| vr_we | output | 1 | Vector register write strobe |
| vr_idx | output | 6 | Element index of the written word |
| vr_data | output | 32 | Word being written |
| done | output | 1 | Load complete |

## Verification
The bench sweeps many strides against varied lengths and checks the exact cycle of every request and every write, so that stalls on a bank conflict are tested as well as addresses. If the busy window were off by one, stride 0 or a multiple of 16 would show requests one cycle early or late. If a later element were allowed to pass a stalled one, requests would arrive out of order. If the write latency were wrong, every write cycle would be off. The bench also covers a zero length (any request would be reported), lengths of 100 and 127 (a missing clamp would produce extra elements), a start pulse during an active load (a unit that accepted it would restart the load), and gather offsets that collide on one bank.

// File: rtl/vlu_pkg.sv
package vlu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } vlu_state_e;
endpackage

// File: rtl/vlu_addr_gen.sv
module vlu_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int MAXVL  = 64,
    localparam int CNT_W = $clog2(MAXVL + 1),
    localparam int IDX_W = $clog2(MAXVL)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     gather_in,
    input  logic [ADDR_W-1:0]        base_in,
    input  logic [ADDR_W-1:0]        stride_in,
    input  logic [MAXVL*ADDR_W-1:0]  offs_in,
    input  logic                     advance,
    output logic [CNT_W-1:0]         elem_idx,
    output logic [ADDR_W-1:0]        elem_addr
);
    logic [CNT_W-1:0]  cur_q;
    logic [ADDR_W-1:0] acc_q, base_q, stride_q;
    logic              gath_q;
    logic [ADDR_W-1:0] offs_q [MAXVL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q    <= '0;
            acc_q    <= '0;
            base_q   <= '0;
            stride_q <= '0;
            gath_q   <= 1'b0;
        end else if (load) begin
            cur_q    <= '0;
            acc_q    <= base_in;
            base_q   <= base_in;
            stride_q <= stride_in;
            gath_q   <= gather_in;
        end else if (advance) begin
            cur_q <= cur_q + CNT_W'(1);
            acc_q <= acc_q + stride_q;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            for (int k = 0; k < MAXVL; k++)
                offs_q[k] <= offs_in[k*ADDR_W +: ADDR_W];
        end
    end

    assign elem_idx  = cur_q;
    assign elem_addr = gath_q ? base_q + offs_q[cur_q[IDX_W-1:0]] : acc_q;
endmodule

// File: rtl/vlu_bank_array.sv
module vlu_bank_array #(
    parameter int ADDR_W = 16,
    parameter int NBANK  = 16,
    parameter int BUSY   = 4,
    parameter int LAT    = 12,
    parameter int IDX_W  = 6,
    parameter logic [15:0] SALT = 16'hA5C3,
    localparam int BANK_W = $clog2(NBANK),
    localparam int BUSY_W = $clog2(BUSY + 1),
    localparam int DATA_W = 2 * ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [IDX_W-1:0]  req_idx,
    output logic              bank_free,
    output logic              rd_valid,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [NBANK-1:0]  free_vec;
    logic [BANK_W-1:0] sel;
    assign sel = req_addr[BANK_W-1:0];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [BUSY_W-1:0] cnt_q;
        logic              hit;
        assign hit = req && (sel == BANK_W'(b));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               cnt_q <= '0;
            else if (hit)             cnt_q <= BUSY_W'(BUSY - 1);
            else if (cnt_q != '0)     cnt_q <= cnt_q - BUSY_W'(1);
        end
        assign free_vec[b] = (cnt_q == '0);

        logic [BUSY_W-1:0] gap_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       gap_q <= BUSY_W'(BUSY);
            else if (hit)                     gap_q <= BUSY_W'(1);
            else if (gap_q < BUSY_W'(BUSY))   gap_q <= gap_q + BUSY_W'(1);
        end
        AST_BANK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            hit |-> gap_q >= BUSY_W'(BUSY)); // R2
    end

    assign bank_free = free_vec[sel];

    logic              pv [LAT];
    logic [IDX_W-1:0]  pi [LAT];
    logic [DATA_W-1:0] pd [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < LAT; k++) pv[k] <= 1'b0;
        end else begin
            pv[0] <= req;
            for (int k = 1; k < LAT; k++) pv[k] <= pv[k-1];
        end
    end

    always_ff @(posedge clk) begin
        pi[0] <= req_idx;
        pd[0] <= {req_addr ^ SALT[ADDR_W-1:0], req_addr};
        for (int k = 1; k < LAT; k++) begin
            pi[k] <= pi[k-1];
            pd[k] <= pd[k-1];
        end
    end

    assign rd_valid = pv[LAT-1];
    assign rd_idx   = pi[LAT-1];
    assign rd_data  = pd[LAT-1];
endmodule

// File: rtl/vec_bank_load.sv
module vec_bank_load
    import vlu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NBANK  = 16,
    parameter int BUSY   = 4,
    parameter int LAT    = 12,
    parameter int MAXVL  = 64,
    localparam int CNT_W  = $clog2(MAXVL + 1),
    localparam int IDX_W  = $clog2(MAXVL),
    localparam int DATA_W = 2 * ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    gather,
    input  logic [ADDR_W-1:0]       base,
    input  logic [ADDR_W-1:0]       stride,
    input  logic [CNT_W-1:0]        vlen,
    input  logic [MAXVL*ADDR_W-1:0] idx_vec,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    vr_we,
    output logic [IDX_W-1:0]        vr_idx,
    output logic [DATA_W-1:0]       vr_data,
    output logic                    done
);
    vlu_state_e state_q, state_d;
    logic [CNT_W-1:0]  vl_q, vl_eff, elem_idx;
    logic              accept, bank_free, last_issue, last_write;

    assign accept = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign vl_eff = (vlen > CNT_W'(MAXVL)) ? CNT_W'(MAXVL) : vlen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      vl_q <= '0;
        else if (accept) vl_q <= vl_eff;
    end

    vlu_addr_gen #(.ADDR_W(ADDR_W), .MAXVL(MAXVL)) u_agen (
        .clk(clk), .rst_n(rst_n), .load(accept), .gather_in(gather),
        .base_in(base), .stride_in(stride), .offs_in(idx_vec),
        .advance(mem_req), .elem_idx(elem_idx), .elem_addr(mem_addr)
    );

    vlu_bank_array #(.ADDR_W(ADDR_W), .NBANK(NBANK), .BUSY(BUSY), .LAT(LAT),
                     .IDX_W(IDX_W)) u_banks (
        .clk(clk), .rst_n(rst_n), .req(mem_req), .req_addr(mem_addr),
        .req_idx(elem_idx[IDX_W-1:0]), .bank_free(bank_free),
        .rd_valid(vr_we), .rd_idx(vr_idx), .rd_data(vr_data)
    );

    assign last_issue = mem_req && (elem_idx == vl_q - CNT_W'(1));
    assign last_write = vr_we && (CNT_W'(vr_idx) == vl_q - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (accept) state_d = (vl_eff == '0) ? ST_DONE : ST_ISSUE;
            ST_ISSUE:         if (last_issue) state_d = ST_DRAIN;
            ST_DRAIN:         if (last_write) state_d = ST_DONE;
            default:          state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req = (state_q == ST_ISSUE) && bank_free;
        done    = (state_q == ST_DONE);
    end

    logic             have_q;
    logic [IDX_W-1:0] prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_q <= 1'b0;
            prev_q <= '0;
        end else if (accept) begin
            have_q <= 1'b0;
        end else if (vr_we) begin
            have_q <= 1'b1;
            prev_q <= vr_idx;
        end
    end

    AST_WRITE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (vr_we && have_q) |-> vr_idx == prev_q + IDX_W'(1)); // R5
    AST_FIRST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (vr_we && !have_q) |-> vr_idx == '0); // R5
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !vr_we && !mem_req); // R7
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R6
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ISSUE && start) |=> $stable(vl_q)); // R9
endmodule

// File: tb/vec_bank_load_tb.sv
module vec_bank_load_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, gather = 1'b0;
    logic [15:0] base = '0, stride = '0;
    logic [6:0]  vlen = '0;
    logic [1023:0] idx_vec = '0;
    logic mem_req, vr_we, done;
    logic [15:0] mem_addr;
    logic [5:0]  vr_idx;
    logic [31:0] vr_data;

    int checks = 0, fails = 0;
    int exp_iss [64];
    logic [15:0] exp_adr [64];

    always #5 clk = ~clk;

    vec_bank_load u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .gather(gather), .base(base),
        .stride(stride), .vlen(vlen), .idx_vec(idx_vec), .mem_req(mem_req),
        .mem_addr(mem_addr), .vr_we(vr_we), .vr_idx(vr_idx), .vr_data(vr_data),
        .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // pattern: 0 stride, 1 gather i*5, 2 gather i*16, 3 gather mixed
    task automatic run(input logic [15:0] b, input logic [15:0] s, input int pat,
                       input int vl_in, input bit poke);
        int vl, free_at [16], k, w, n, exp_done;
        logic [15:0] off;
        vl = (vl_in > 64) ? 64 : vl_in;
        for (int j = 0; j < 16; j++) free_at[j] = 0;
        for (int i = 0; i < 64; i++) begin
            case (pat)
                1: off = 16'(i * 5);
                2: off = 16'(i * 16);
                3: off = 16'((i * 7 + 3) ^ (i << 4));
                default: off = 16'(i);
            endcase
            idx_vec[i*16 +: 16] = off;
            exp_adr[i] = (pat == 0) ? 16'(b + 16'(i) * s) : 16'(b + off);
        end
        for (int i = 0; i < vl; i++) begin
            int t;
            t = (i == 0) ? 1 : exp_iss[i-1] + 1;
            if (free_at[exp_adr[i][3:0]] > t) t = free_at[exp_adr[i][3:0]];
            free_at[exp_adr[i][3:0]] = t + 4;
            exp_iss[i] = t;
        end
        exp_done = (vl == 0) ? 1 : exp_iss[vl-1] + 13;
        @(negedge clk);
        base = b; stride = s; gather = (pat != 0); vlen = 7'(vl_in); start = 1'b1;
        k = 0; w = 0; n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (n == 1) start = 1'b0;
            if (poke && n == 5) begin
                start = 1'b1; vlen = 7'd3; base = 16'h7777; stride = 16'd1; gather = 1'b0;
            end
            if (poke && n == 6) start = 1'b0;
            if (n == 1 && vl > 0) chk(done == 1'b0, "R6 done cleared", done, 0);
            if (mem_req) begin
                chk(k < vl, "R7/R8 request count", k, vl);
                if (k < vl) begin
                    chk(n == exp_iss[k], "R2 issue cycle", n, exp_iss[k]);
                    chk(mem_addr == exp_adr[k], "R3/R4 address", mem_addr, exp_adr[k]);
                end
                k++;
            end
            if (vr_we) begin
                if (w < vl) begin
                    chk(vr_idx == 6'(w), "R5 write index", vr_idx, w);
                    chk(n == exp_iss[w] + 12, "R5 write cycle", n, exp_iss[w] + 12);
                    chk(vr_data == {exp_adr[w] ^ 16'hA5C3, exp_adr[w]}, "R5 data",
                        vr_data, {exp_adr[w] ^ 16'hA5C3, exp_adr[w]});
                end else chk(1'b0, "R9 extra write", w, vl);
                w++;
            end
            if (done) begin
                chk(n == exp_done, "R6 done cycle", n, exp_done);
                chk(k == vl && w == vl, "R8 element total", w, vl);
                break;
            end
            if (n > 400) begin
                chk(1'b0, "watchdog", n, exp_done);
                break;
            end
        end
        @(negedge clk);
        chk(done == 1'b1, "R6 done held", done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && !mem_req && !vr_we, "R10 reset state", {done, mem_req, vr_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_req && !vr_we, "R10 idle after reset", {done, mem_req, vr_we}, 0);
        run(16'h0100, 16'd1, 0, 64, 1'b0);           // R1 unit stride, full rate
        for (int s = 0; s < 34; s++)                 // R2 R3 stride sweep
            run(16'(s * 37), 16'(s), 0, 1 + (s * 7) % 64, 1'b0);
        run(16'h0040, 16'd48, 0, 64, 1'b0);          // R2 one bank only
        run(16'h0005, 16'hFFFF, 0, 20, 1'b0);        // R3 downward
        run(16'hFFF8, 16'd3, 0, 30, 1'b0);           // R3 wrap
        run(16'h1234, 16'd0, 0, 0, 1'b0);            // R7 zero length
        run(16'h1234, 16'd1, 0, 0, 1'b0);            // R7 back to back
        run(16'h0200, 16'd1, 0, 100, 1'b0);          // R8 clamp
        run(16'h0300, 16'd2, 0, 127, 1'b0);          // R8 clamp max
        run(16'h0400, 16'd5, 0, 24, 1'b1);           // R9 start while busy
        run(16'h0500, 16'd0, 1, 40, 1'b0);           // R4 gather
        run(16'h0600, 16'd0, 2, 64, 1'b0);           // R4 gather same bank
        run(16'h0700, 16'd0, 3, 64, 1'b0);           // R4 gather mixed
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule